// File: doc/BRIEF.md
# Joinable Dual-Direction Word Queue Pair

This block sits between a host processor and a small timing sequencer. It carries two queues of 32-bit words. The outbound queue takes words from the host and hands them to the sequencer. The inbound queue takes words from the sequencer and hands them to the host. Each queue has a push port and a pop port. Each queue reports full, empty and a fill level. Each queue has sticky overflow and underflow flags, and the host clears them by writing ones.

A static two-bit configuration input can merge the storage of both queues into one queue of twice the depth for one chosen direction. The queue for the other direction is then closed. Changing the configuration empties both queues.

A pop port presents the head word combinationally while its queue holds data. It presents zero when the queue is empty. The word is consumed at the clock edge where the pop request is high. A push is written at the edge where the push request is high, if the queue has room.

Top module: `hq_fifo_pair`

## Requirements
- R1: Words are 32 bits wide and leave each queue in exactly the order they were accepted. With `join_mode` at 2'b00 or 2'b11, each queue holds up to 4 words.
- R2: `tx_level` and `rx_level` count the words held, from 0 up to the current capacity. Full is high when the level equals the capacity and empty is high when the level is 0. The level changes at the edge that completes a transfer. After reset both levels are 0, both queues are empty and all flags are 0.
- R3: A push while the queue is full is dropped and the level does not change. At that edge the queue's sticky overflow flag goes to 1.
- R4: A pop while the queue is empty reads zero on the pop data port and leaves the level unchanged. At that edge the queue's sticky underflow flag goes to 1.
- R5: A push and a pop in the same cycle, on a queue that is neither full nor empty, both complete and leave the level unchanged.
- R6: The bits of `flag_clear` clear flags at the next edge: bit 0 clears the outbound overflow flag, bit 1 the outbound underflow flag, bit 2 the inbound overflow flag and bit 3 the inbound underflow flag. When a clear and a new error arrive for the same flag at the same edge, the flag stays at 1.
- R7: With `join_mode` at 2'b01, the outbound queue holds up to 8 words in order. The inbound queue is closed: both its full and empty read 1, its level reads 0, and pushes and pops to it raise its overflow and underflow flags.
- R8: With `join_mode` at 2'b10, the inbound queue holds up to 8 words in order, and the outbound queue is closed in the same way as in R7.
- R9: At the first edge after `join_mode` changes, both queues are emptied and both levels become 0. Pushes and pops in that cycle transfer nothing and change no flag.
- R10: While a queue holds data, its pop data port shows the oldest word before the edge. The pop at that edge removes the word, and the next word appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| join_mode | input | 2 | 00/11 separate, 01 merged outbound, 10 merged inbound |
| host_tx_push | input | 1 | Host writes a word into the outbound queue |
| host_tx_wdata | input | 32 | Word written by the host |
| host_tx_full | output | 1 | Outbound queue full |
| seq_tx_pop | input | 1 | Sequencer takes the head outbound word |
| seq_tx_rdata | output | 32 | Head outbound word, zero when empty |
| seq_tx_empty | output | 1 | Outbound queue empty |
| seq_rx_push | input | 1 | Sequencer writes a word into the inbound queue |
| seq_rx_wdata | input | 32 | Word written by the sequencer |
| seq_rx_full | output | 1 | Inbound queue full |
| host_rx_pop | input | 1 | Host takes the head inbound word |
| host_rx_rdata | output | 32 | Head inbound word, zero when empty |
| host_rx_empty | output | 1 | Inbound queue empty |
| tx_level | output | 4 | Outbound fill level |
| rx_level | output | 4 | Inbound fill level |
| flag_clear | input | 4 | Write-one-to-clear strobes for the four sticky flags |
| tx_overflow | output | 1 | Sticky outbound overflow |
| tx_underflow | output | 1 | Sticky outbound underflow |
| rx_overflow | output | 1 | Sticky inbound overflow |
| rx_underflow | output | 1 | Sticky inbound underflow |

## Verification
The pop data ports are combinational. The bench samples them 1 ns after it drives a pop request, before the edge that consumes the word. It compares them with the head of its own model queue, or with zero when the model queue is empty. Levels, full, empty and the sticky flags all change at the edge that follows the stimulus. The bench applies every stimulus at a falling edge and reads these results at the next falling edge, which is exactly one register stage later. A change of `join_mode` empties the queues at the following edge, so the bench checks both levels for zero at the falling edge after that.

// File: rtl/hq_pkg.sv
package hq_pkg;
  typedef enum logic [1:0] {
    JM_SPLIT  = 2'b00,
    JM_TX     = 2'b01,
    JM_RX     = 2'b10,
    JM_SPLIT2 = 2'b11
  } join_e;

  localparam int Q_TX = 0;
  localparam int Q_RX = 1;
  localparam int NUM_Q = 2;
endpackage

// File: rtl/hq_join_cfg.sv
module hq_join_cfg
  import hq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = $clog2(2 * DEPTH),
  parameter int LW    = $clog2(2 * DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                join_mode,
  output logic [1:0]                mode_q,
  output logic                      flush,
  output logic [NUM_Q-1:0][LW-1:0]  q_cap,
  output logic [NUM_Q-1:0][PW-1:0]  q_base
);
  function automatic logic [LW-1:0] cap_of(input logic [1:0] m, input int q);
    logic [LW-1:0] c;
    case (join_e'(m))
      JM_TX:   c = (q == Q_TX) ? LW'(2 * DEPTH) : '0;
      JM_RX:   c = (q == Q_RX) ? LW'(2 * DEPTH) : '0;
      default: c = LW'(DEPTH);
    endcase
    return c;
  endfunction

  function automatic logic [PW-1:0] base_of(input logic [1:0] m, input int q);
    logic [PW-1:0] b;
    if (q == Q_TX || join_e'(m) == JM_RX) b = '0;
    else                                  b = PW'(DEPTH);
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= JM_SPLIT;
    else        mode_q <= join_mode;
  end

  assign flush = (join_mode != mode_q);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_cfg
    assign q_cap[q]  = cap_of(mode_q, q);
    assign q_base[q] = base_of(mode_q, q);
  end
endmodule

// File: rtl/hq_ctrl.sv
module hq_ctrl #(
  parameter int DEPTH = 4,
  parameter int PW    = $clog2(2 * DEPTH),
  parameter int LW    = $clog2(2 * DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [LW-1:0] cap,
  input  logic          push,
  input  logic          pop,
  input  logic          clr_ovf,
  input  logic          clr_udf,
  output logic          push_acc,
  output logic          pop_acc,
  output logic          push_rej,
  output logic          pop_rej,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          udf
);
  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p,
                                            input logic [LW-1:0] c);
    logic [LW-1:0] w;
    w = LW'(p) + LW'(1);
    return (w >= c) ? '0 : PW'(w);
  endfunction

  function automatic logic [LW-1:0] lvl_next(input logic [LW-1:0] l,
                                             input logic inc, input logic dec);
    return l + LW'(inc) - LW'(dec);
  endfunction

  assign full  = (level == cap);
  assign empty = (level == '0);

  assign push_acc = push && !full  && !flush;
  assign pop_acc  = pop  && !empty && !flush;
  assign push_rej = push && full   && !flush;
  assign pop_rej  = pop  && empty  && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_acc) wr_ptr <= ptr_inc(wr_ptr, cap);
      if (pop_acc)  rd_ptr <= ptr_inc(rd_ptr, cap);
      level <= lvl_next(level, push_acc, pop_acc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      ovf <= push_rej | (ovf & ~clr_ovf);
      udf <= pop_rej  | (udf & ~clr_udf);
    end
  end
endmodule

// File: rtl/hq_store.sv
module hq_store #(
  parameter int W       = 32,
  parameter int ENTRIES = 8,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic [1:0]           we,
  input  logic [1:0][AW-1:0]   waddr,
  input  logic [1:0][W-1:0]    wdata,
  input  logic [1:0][AW-1:0]   raddr,
  output logic [1:0][W-1:0]    rdata
);
  logic [W-1:0] mem [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we[0] && waddr[0] == AW'(e))      mem[e] <= wdata[0];
      else if (we[1] && waddr[1] == AW'(e)) mem[e] <= wdata[1];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/hq_fifo_pair.sv
module hq_fifo_pair
  import hq_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  parameter int PW    = $clog2(2 * DEPTH),
  parameter int LW    = $clog2(2 * DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    join_mode,
  input  logic          host_tx_push,
  input  logic [W-1:0]  host_tx_wdata,
  output logic          host_tx_full,
  input  logic          seq_tx_pop,
  output logic [W-1:0]  seq_tx_rdata,
  output logic          seq_tx_empty,
  input  logic          seq_rx_push,
  input  logic [W-1:0]  seq_rx_wdata,
  output logic          seq_rx_full,
  input  logic          host_rx_pop,
  output logic [W-1:0]  host_rx_rdata,
  output logic          host_rx_empty,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  input  logic [3:0]    flag_clear,
  output logic          tx_overflow,
  output logic          tx_underflow,
  output logic          rx_overflow,
  output logic          rx_underflow
);
  localparam int ENTRIES = 2 * DEPTH;

  logic [1:0]                mode_q;
  logic                      flush;
  logic [NUM_Q-1:0][LW-1:0]  q_cap;
  logic [NUM_Q-1:0][PW-1:0]  q_base;

  logic [NUM_Q-1:0]          q_push, q_pop, q_full, q_empty, q_ovf, q_udf;
  logic [NUM_Q-1:0]          q_push_acc, q_pop_acc, q_push_rej, q_pop_rej;
  logic [NUM_Q-1:0][PW-1:0]  q_wptr, q_rptr, q_widx, q_ridx;
  logic [NUM_Q-1:0][LW-1:0]  q_level;
  logic [NUM_Q-1:0][W-1:0]   q_wdata, q_head;

  hq_join_cfg #(.DEPTH(DEPTH), .PW(PW), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .join_mode(join_mode),
    .mode_q(mode_q), .flush(flush), .q_cap(q_cap), .q_base(q_base)
  );

  assign q_push[Q_TX]  = host_tx_push;
  assign q_wdata[Q_TX] = host_tx_wdata;
  assign q_pop[Q_TX]   = seq_tx_pop;
  assign q_push[Q_RX]  = seq_rx_push;
  assign q_wdata[Q_RX] = seq_rx_wdata;
  assign q_pop[Q_RX]   = host_rx_pop;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    hq_ctrl #(.DEPTH(DEPTH), .PW(PW), .LW(LW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .flush(flush), .cap(q_cap[q]),
      .push(q_push[q]), .pop(q_pop[q]),
      .clr_ovf(flag_clear[2*q]), .clr_udf(flag_clear[2*q+1]),
      .push_acc(q_push_acc[q]), .pop_acc(q_pop_acc[q]),
      .push_rej(q_push_rej[q]), .pop_rej(q_pop_rej[q]),
      .wr_ptr(q_wptr[q]), .rd_ptr(q_rptr[q]), .level(q_level[q]),
      .full(q_full[q]), .empty(q_empty[q]), .ovf(q_ovf[q]), .udf(q_udf[q])
    );
    assign q_widx[q] = q_base[q] + q_wptr[q];
    assign q_ridx[q] = q_base[q] + q_rptr[q];
  end

  hq_store #(.W(W), .ENTRIES(ENTRIES), .AW(PW)) u_store (
    .clk(clk), .we(q_push_acc), .waddr(q_widx), .wdata(q_wdata),
    .raddr(q_ridx), .rdata(q_head)
  );

  assign host_tx_full  = q_full[Q_TX];
  assign seq_tx_empty  = q_empty[Q_TX];
  assign seq_tx_rdata  = q_empty[Q_TX] ? '0 : q_head[Q_TX];
  assign seq_rx_full   = q_full[Q_RX];
  assign host_rx_empty = q_empty[Q_RX];
  assign host_rx_rdata = q_empty[Q_RX] ? '0 : q_head[Q_RX];
  assign tx_level      = q_level[Q_TX];
  assign rx_level      = q_level[Q_RX];
  assign tx_overflow   = q_ovf[Q_TX];
  assign tx_underflow  = q_udf[Q_TX];
  assign rx_overflow   = q_ovf[Q_RX];
  assign rx_underflow  = q_udf[Q_RX];
endmodule

// File: rtl/hq_fifo_pair_chk.sv
module hq_fifo_pair_chk #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(2 * DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [1:0]    mode_q,
  input logic [3:0]    flag_clear,
  input logic          host_tx_push,
  input logic          host_tx_full,
  input logic          seq_tx_pop,
  input logic          seq_tx_empty,
  input logic [W-1:0]  seq_tx_rdata,
  input logic          seq_rx_full,
  input logic          host_rx_empty,
  input logic [W-1:0]  host_rx_rdata,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_overflow
);
  // R2: level never exceeds the merged capacity, nor the split one when split
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(2 * DEPTH)) && (rx_level <= LW'(2 * DEPTH)) &&
    ((mode_q == 2'b01 || mode_q == 2'b10) ||
     (tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH))));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    host_tx_push && host_tx_full && !seq_tx_pop && !flush |=> $stable(tx_level));

  a_r3_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_overflow) |-> $past(host_tx_push && host_tx_full && !flush));

  a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_tx_empty |-> seq_tx_rdata == '0) and (host_rx_empty |-> host_rx_rdata == '0));

  a_r5_pushpop_level: assert property (@(posedge clk) disable iff (!rst_n)
    host_tx_push && seq_tx_pop && !host_tx_full && !seq_tx_empty && !flush
    |=> $stable(tx_level));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clear[0] && !(host_tx_push && host_tx_full && !flush) |=> !tx_overflow);

  a_r7_rx_closed: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'b01 |-> seq_rx_full && host_rx_empty && rx_level == '0);

  a_r8_tx_closed: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'b10 |-> host_tx_full && seq_tx_empty && tx_level == '0);

  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> tx_level == '0 && rx_level == '0);
endmodule

bind hq_fifo_pair hq_fifo_pair_chk #(.W(W), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .mode_q(mode_q),
  .flag_clear(flag_clear), .host_tx_push(host_tx_push),
  .host_tx_full(host_tx_full), .seq_tx_pop(seq_tx_pop),
  .seq_tx_empty(seq_tx_empty), .seq_tx_rdata(seq_tx_rdata),
  .seq_rx_full(seq_rx_full), .host_rx_empty(host_rx_empty),
  .host_rx_rdata(host_rx_rdata), .tx_level(tx_level), .rx_level(rx_level),
  .tx_overflow(tx_overflow)
);

// File: tb/test_hq_fifo_pair.sv
`timescale 1ns/1ps
module test_hq_fifo_pair;
  localparam int W = 32;
  localparam int DEPTH = 4;
  localparam int LW = $clog2(2 * DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] join_mode = 2'b00;
  logic host_tx_push = 0, seq_tx_pop = 0, seq_rx_push = 0, host_rx_pop = 0;
  logic [W-1:0] host_tx_wdata = '0, seq_rx_wdata = '0;
  logic [3:0] flag_clear = '0;
  logic host_tx_full, seq_tx_empty, seq_rx_full, host_rx_empty;
  logic [W-1:0] seq_tx_rdata, host_rx_rdata;
  logic [LW-1:0] tx_level, rx_level;
  logic tx_overflow, tx_underflow, rx_overflow, rx_underflow;

  always #2 clk = ~clk;

  hq_fifo_pair i_hq_fifo_pair (
    .clk(clk), .rst_n(rst_n), .join_mode(join_mode),
    .host_tx_push(host_tx_push), .host_tx_wdata(host_tx_wdata),
    .host_tx_full(host_tx_full), .seq_tx_pop(seq_tx_pop),
    .seq_tx_rdata(seq_tx_rdata), .seq_tx_empty(seq_tx_empty),
    .seq_rx_push(seq_rx_push), .seq_rx_wdata(seq_rx_wdata),
    .seq_rx_full(seq_rx_full), .host_rx_pop(host_rx_pop),
    .host_rx_rdata(host_rx_rdata), .host_rx_empty(host_rx_empty),
    .tx_level(tx_level), .rx_level(rx_level), .flag_clear(flag_clear),
    .tx_overflow(tx_overflow), .tx_underflow(tx_underflow),
    .rx_overflow(rx_overflow), .rx_underflow(rx_underflow)
  );

  int total = 0;
  int bad = 0;
  string ctx = "R2";

  // scoreboard: expected words and flags per direction
  logic [W-1:0] sb_tx[$];
  logic [W-1:0] sb_rx[$];
  logic [1:0] m_mode = 2'b00;
  logic m_tovf = 0, m_tudf = 0, m_rovf = 0, m_rudf = 0;

  function automatic int cap_tx(input logic [1:0] m);
    return (m == 2'b01) ? 2 * DEPTH : (m == 2'b10) ? 0 : DEPTH;
  endfunction
  function automatic int cap_rx(input logic [1:0] m);
    return (m == 2'b10) ? 2 * DEPTH : (m == 2'b01) ? 0 : DEPTH;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] %s: actual=%0h expected=%0h", req, ctx, what, act, exp);
    end
  endtask

  // monitor: compare every port against the scoreboard state
  task automatic check_state();
    check(tx_level == LW'(sb_tx.size()), "R2", "tx_level", W'(tx_level), W'(sb_tx.size()));
    check(rx_level == LW'(sb_rx.size()), "R2", "rx_level", W'(rx_level), W'(sb_rx.size()));
    check(host_tx_full == (sb_tx.size() == cap_tx(m_mode)), "R2", "tx_full",
          W'(host_tx_full), W'(sb_tx.size() == cap_tx(m_mode)));
    check(seq_tx_empty == (sb_tx.size() == 0), "R2", "tx_empty",
          W'(seq_tx_empty), W'(sb_tx.size() == 0));
    check(seq_rx_full == (sb_rx.size() == cap_rx(m_mode)), "R2", "rx_full",
          W'(seq_rx_full), W'(sb_rx.size() == cap_rx(m_mode)));
    check(host_rx_empty == (sb_rx.size() == 0), "R2", "rx_empty",
          W'(host_rx_empty), W'(sb_rx.size() == 0));
    check(tx_overflow == m_tovf, "R3", "tx_overflow", W'(tx_overflow), W'(m_tovf));
    check(rx_overflow == m_rovf, "R3", "rx_overflow", W'(rx_overflow), W'(m_rovf));
    check(tx_underflow == m_tudf, "R4", "tx_underflow", W'(tx_underflow), W'(m_tudf));
    check(rx_underflow == m_rudf, "R4", "rx_underflow", W'(rx_underflow), W'(m_rudf));
  endtask

  // driver: one cycle of stimulus, called at a falling edge
  task automatic step(input bit tp, input logic [W-1:0] td, input bit tq,
                      input bit rp, input logic [W-1:0] rd, input bit rq,
                      input logic [3:0] clr);
    logic [W-1:0] exp;
    bit t_ok_pop, t_ok_push, r_ok_pop, r_ok_push;
    host_tx_push = tp; host_tx_wdata = td; seq_tx_pop = tq;
    seq_rx_push = rp;  seq_rx_wdata = rd;  host_rx_pop = rq;
    flag_clear = clr;
    #1;
    if (tq) begin
      exp = (sb_tx.size() > 0) ? sb_tx[0] : '0;
      check(seq_tx_rdata == exp, (sb_tx.size() > 0) ? "R10" : "R4",
            "seq_tx_rdata", seq_tx_rdata, exp);
    end
    if (rq) begin
      exp = (sb_rx.size() > 0) ? sb_rx[0] : '0;
      check(host_rx_rdata == exp, (sb_rx.size() > 0) ? "R1" : "R4",
            "host_rx_rdata", host_rx_rdata, exp);
    end
    t_ok_pop  = sb_tx.size() > 0;
    t_ok_push = sb_tx.size() < cap_tx(m_mode);
    r_ok_pop  = sb_rx.size() > 0;
    r_ok_push = sb_rx.size() < cap_rx(m_mode);
    m_tovf = (m_tovf & ~clr[0]) | (tp & ~t_ok_push);
    m_tudf = (m_tudf & ~clr[1]) | (tq & ~t_ok_pop);
    m_rovf = (m_rovf & ~clr[2]) | (rp & ~r_ok_push);
    m_rudf = (m_rudf & ~clr[3]) | (rq & ~r_ok_pop);
    if (tq && t_ok_pop)  void'(sb_tx.pop_front());
    if (tp && t_ok_push) sb_tx.push_back(td);
    if (rq && r_ok_pop)  void'(sb_rx.pop_front());
    if (rp && r_ok_push) sb_rx.push_back(rd);
    @(negedge clk);
    host_tx_push = 0; seq_tx_pop = 0; seq_rx_push = 0; host_rx_pop = 0;
    flag_clear = '0;
    check_state();
  endtask

  // configuration change with transfer attempts in the flush cycle
  task automatic set_mode(input logic [1:0] m);
    join_mode = m;
    host_tx_push = 1; host_tx_wdata = 32'hdead0000;
    seq_rx_push = 1;  seq_rx_wdata = 32'hdead1111;
    seq_tx_pop = 1;   host_rx_pop = 1;
    @(negedge clk);
    host_tx_push = 0; seq_rx_push = 0; seq_tx_pop = 0; host_rx_pop = 0;
    m_mode = m;
    sb_tx.delete();
    sb_rx.delete();
    ctx = "R9";
    check(tx_level == '0 && rx_level == '0, "R9", "levels after mode change",
          W'({tx_level, rx_level}), '0);
    check_state();
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ctx = "R2 reset";
    check_state();

    // R1 R3: fill outbound queue, overflow, then drain in order
    ctx = "R1";
    for (int i = 0; i < DEPTH; i++) step(1, 32'h1000 + i, 0, 0, 0, 0, 4'h0);
    ctx = "R3";
    step(1, 32'hbad0, 0, 0, 0, 0, 4'h0);
    step(1, 32'hbad1, 0, 0, 0, 0, 4'h0);
    ctx = "R1";
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 0, 4'h0);
    ctx = "R4";
    step(0, 0, 1, 0, 0, 1, 4'h0);

    // R6: clear flags, and set-versus-clear in the same cycle
    ctx = "R6";
    step(0, 0, 0, 0, 0, 0, 4'hf);
    step(0, 0, 1, 0, 0, 0, 4'h2);
    check(tx_underflow == 1'b1, "R6", "set wins over clear", W'(tx_underflow), 1);
    step(0, 0, 0, 0, 0, 0, 4'h2);

    // R5 R10: inbound traffic with simultaneous push and pop
    ctx = "R5";
    step(0, 0, 0, 1, 32'ha0, 0, 4'h0);
    step(0, 0, 0, 1, 32'ha1, 0, 4'h0);
    step(0, 0, 0, 1, 32'ha2, 1, 4'h0);
    check(rx_level == LW'(2), "R5", "level held by push+pop", W'(rx_level), 2);
    step(1, 32'hb0, 0, 0, 0, 0, 4'h0);
    step(1, 32'hb1, 1, 0, 0, 0, 4'h0);
    check(tx_level == LW'(1), "R5", "tx level held by push+pop", W'(tx_level), 1);
    ctx = "R10";
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 1, 4'h0);
    step(0, 0, 0, 0, 0, 0, 4'hf);

    // R7: merged outbound queue of 8
    set_mode(2'b01);
    ctx = "R7";
    for (int i = 0; i < 2 * DEPTH; i++) step(1, 32'hc000 + i * 3, 0, 0, 0, 0, 4'h0);
    check(host_tx_full && tx_level == LW'(2 * DEPTH), "R7", "merged full",
          W'(tx_level), 2 * DEPTH);
    step(1, 32'hbad2, 0, 1, 32'hbad3, 1, 4'h0);
    check(seq_rx_full && host_rx_empty, "R7", "inbound closed",
          W'({seq_rx_full, host_rx_empty}), 3);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, 4'h0);
    for (int i = 0; i < 3; i++) step(1, 32'hd000 + i, 1, 0, 0, 0, 4'h0);
    for (int i = 0; i < 2 * DEPTH + 1; i++) step(0, 0, 1, 0, 0, 0, 4'h0);
    step(0, 0, 0, 0, 0, 0, 4'hf);

    // R9 R8: flush a part-filled queue, then merged inbound queue
    for (int i = 0; i < 3; i++) step(1, 32'he0 + i, 0, 0, 0, 0, 4'h0);
    set_mode(2'b10);
    ctx = "R8";
    for (int i = 0; i < 2 * DEPTH; i++) step(0, 0, 0, 1, 32'hf000 + i * 7, 0, 4'h0);
    check(seq_rx_full && rx_level == LW'(2 * DEPTH), "R8", "merged full",
          W'(rx_level), 2 * DEPTH);
    step(1, 32'hbad4, 1, 1, 32'hbad5, 0, 4'h0);
    check(host_tx_full && seq_tx_empty, "R8", "outbound closed",
          W'({host_tx_full, seq_tx_empty}), 3);
    for (int i = 0; i < 2 * DEPTH; i++) step(0, 0, 0, 0, 0, 1, 4'h0);
    step(0, 0, 0, 0, 0, 0, 4'hf);

    // R1: code 11 behaves as split with 4 entries each
    set_mode(2'b11);
    ctx = "R1 split2";
    for (int i = 0; i < DEPTH + 1; i++) step(1, 32'h5500 + i, 0, 1, 32'h6600 + i, 0, 4'h0);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 1, 4'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule